// File: doc/BRIEF.md
# Dual-Rail Phase Completion Detector

This block watches a word carried on dual-rail wires and tells the previous pipeline stage when the word has finished a phase. Operation alternates between a work phase and a spacer phase. Each work value is separated from the next by a spacer. Every bit travels as a pair of rails (a true rail and a false rail). Each bit has its own indicator. The indicator is set once the bit shows a valid work codeword, and it is cleared only once the bit is back at the spacer code. It holds its value in every other case.

The per-bit indicators are merged through a tree of hysteresis merge elements. The tree is grouped by a parameter. The resulting acknowledge rises only when every indicator is set, and falls only when every indicator is clear. A one-bit indicator from the next stage's input register is one more leaf of the top merge element. The acknowledge therefore also waits for the stage downstream.

A parameter selects the spacer encoding:
- **Zero spacer:** the spacer is both rails low, and both rails high is illegal.
- **Unit spacer:** the spacer is both rails high, and both rails low is illegal.

An illegal pair raises an error output.

Top module: `dr_completion_ind`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ack_prev` and `code_err` are 0.
- R2: Once every bit holds a work codeword (exactly one rail high; true rail high means 1, false rail high means 0) and `down_ind` is 1, `ack_prev` becomes 1 on the third rising clock edge after the inputs are applied, and not before.
- R3: While at least one bit is still at the spacer code, `ack_prev` stays 0 even if all other bits hold work codewords.
- R4: After `ack_prev` is 1, it stays 1 while any bit is still at a work codeword or `down_ind` is 1. It returns to 0 only after every bit is at the spacer code and `down_ind` is 0.
- R5: `down_ind` is a leaf of the merge. With all bits at work codewords and `down_ind` at 0, `ack_prev` stays 0, and it rises after `down_ind` goes to 1.
- R6: An illegal rail pair leaves that bit's indicator unchanged. A bit that was set stays set, and a bit that was clear stays clear. This holds until the bit shows a legal code.
- R7: `code_err` is 1 on the clock cycle after any bit shows the illegal pair, and 0 on the clock cycle after no bit does. With `UNIT_SP`=0 the illegal pair is both rails high.
- R8: With `UNIT_SP`=1, the spacer is both rails high, the illegal pair is both rails low, and R2 to R7 hold with these codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Active-high synchronous reset |
| rail_t | input | WIDTH | True rail of each bit |
| rail_f | input | WIDTH | False rail of each bit |
| down_ind | input | 1 | Completion indicator of the next stage's input register |
| ack_prev | output | 1 | Acknowledge to the previous stage (merged phase done) |
| code_err | output | 1 | Illegal rail pair seen on some bit in the previous cycle |

## Verification
The error flag and the hysteresis hold of the acknowledge can fall in the same cycle. This happens when a bit that has already been indicated as work turns illegal while every other bit returns to spacer. The bench provokes this, and expects `code_err` high while `ack_prev` stays high, because the illegal bit keeps its indicator set. It then expects both outputs to drop once that bit reaches spacer. The mirror case is also provoked: a bit turns illegal while the word is at spacer. The bench expects the error together with a held-low acknowledge that ignores later work on the other bits, and this is checked in both spacer encodings.

// File: rtl/dr_cmp_pkg.sv
package dr_cmp_pkg;

  typedef enum logic [1:0] {
    CODE_SPACER = 2'd0,
    CODE_WORK   = 2'd1,
    CODE_BAD    = 2'd2
  } code_e;

  // Classify one rail pair under the chosen spacer encoding.
  function automatic code_e classify(input logic unit_sp, input logic t, input logic f);
    if (t ^ f)         return CODE_WORK;
    else if (t == unit_sp) return CODE_SPACER;
    else               return CODE_BAD;
  endfunction

  // Two-input hysteresis (C-element) next state: set on both, clear on neither.
  function automatic logic celem_next(input logic a, input logic b, input logic q);
    return (a & b) | (q & (a | b));
  endfunction

endpackage

// File: rtl/dr_bit_ind.sv
module dr_bit_ind
  import dr_cmp_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter bit UNIT_SP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic [WIDTH-1:0] ind,
  output logic             bad_flag
);

  logic [WIDTH-1:0] is_work;
  logic [WIDTH-1:0] is_spacer;
  logic [WIDTH-1:0] is_bad;
  logic [WIDTH-1:0] ind_nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    code_e code;
    always_comb code = classify(UNIT_SP, rail_t[i], rail_f[i]);
    assign is_work[i]   = (code == CODE_WORK);
    assign is_spacer[i] = (code == CODE_SPACER);
    assign is_bad[i]    = (code == CODE_BAD);
    // "work seen" and "not at spacer" feed the hysteresis element;
    // an illegal pair gives 0/1 and therefore holds.
    assign ind_nxt[i]   = celem_next(is_work[i], ~is_spacer[i], ind[i]);

    // R6
    ind_bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
      is_bad[i] |=> $stable(ind[i]));
    // R2
    ind_set_chk: assert property (@(posedge clk) disable iff (rst)
      is_work[i] |=> ind[i]);
    // R4
    ind_clr_chk: assert property (@(posedge clk) disable iff (rst)
      is_spacer[i] |=> !ind[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ind      <= '0;
      bad_flag <= 1'b0;
    end else begin
      ind      <= ind_nxt;
      bad_flag <= |is_bad;
    end
  end

  // R7
  bad_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|is_bad) |=> bad_flag);
  // R7
  bad_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(|is_bad) |=> !bad_flag);

endmodule

// File: rtl/dr_c_merge.sv
module dr_c_merge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_vec,
  output logic         q
);

  logic all_set;
  logic all_clr;

  assign all_set = &in_vec;
  assign all_clr = ~|in_vec;

  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (all_set) q <= 1'b1;
    else if (all_clr) q <= 1'b0;
  end

  // R3
  mixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(all_set || all_clr) |=> $stable(q));
  // R4
  merge_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(q) |-> $past(all_clr));
  // R2
  merge_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(all_set));

endmodule

// File: rtl/dr_completion_ind.sv
module dr_completion_ind #(
  parameter int WIDTH   = 64,
  parameter int GROUP   = 8,
  parameter bit UNIT_SP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  input  logic             down_ind,
  output logic             ack_prev,
  output logic             code_err
);

  localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;

  logic [WIDTH-1:0] bit_ind;
  logic [NGRP-1:0]  grp_done;
  logic             merged;

  dr_bit_ind #(.WIDTH(WIDTH), .UNIT_SP(UNIT_SP)) u_bits (
    .clk      (clk),
    .rst      (rst),
    .rail_t   (rail_t),
    .rail_f   (rail_f),
    .ind      (bit_ind),
    .bad_flag (code_err)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = g * GROUP;
    localparam int HI = ((LO + GROUP) > WIDTH) ? (WIDTH - 1) : (LO + GROUP - 1);
    dr_c_merge #(.N(HI - LO + 1)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .in_vec (bit_ind[HI:LO]),
      .q      (grp_done[g])
    );
  end

  dr_c_merge #(.N(NGRP + 1)) u_top (
    .clk    (clk),
    .rst    (rst),
    .in_vec ({down_ind, grp_done}),
    .q      (merged)
  );

  assign ack_prev = merged;

  // R1
  rst_out_chk: assert property (@(posedge clk)
    rst |=> (!ack_prev && !code_err));
  // R5
  ack_rise_down_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_prev) |-> $past(down_ind));
  // R4
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_prev) |-> $past(!down_ind && !(|grp_done)));
  // R2
  ack_rise_grp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_prev) |-> $past(&grp_done));

endmodule

// File: tb/tb_dr_completion_ind.sv
module tb_dr_completion_ind;

  localparam int ZW = 64;
  localparam int UW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [ZW-1:0] zt = '0, zf = '0;
  logic          zdown = 1'b0;
  logic          z_ack, z_err;
  logic [UW-1:0] ut = '1, uf = '1;
  logic          udown = 1'b0;
  logic          u_ack, u_err;

  dr_completion_ind #(.WIDTH(ZW), .GROUP(8), .UNIT_SP(1'b0)) dut (
    .clk(clk), .rst(rst), .rail_t(zt), .rail_f(zf), .down_ind(zdown),
    .ack_prev(z_ack), .code_err(z_err));

  dr_completion_ind #(.WIDTH(UW), .GROUP(4), .UNIT_SP(1'b1)) dut_unit (
    .clk(clk), .rst(rst), .rail_t(ut), .rail_f(uf), .down_ind(udown),
    .ack_prev(u_ack), .code_err(u_err));

  typedef struct {
    bit    unit;
    bit    ack;
    bit    err;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   reported = 1'b0;

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ack/err actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Zero-spacer word: bits in mask carry data w, others at spacer (00).
  task automatic apply_z(input logic [ZW-1:0] w, input logic [ZW-1:0] m,
                         input logic [ZW-1:0] bad, input logic down,
                         input bit ea, input bit ee, input string tag);
    exp_t e;
    @(negedge clk);
    zt    = (w & m) | bad;
    zf    = (~w & m) | bad;
    zdown = down;
    repeat (3) @(posedge clk);
    #1;
    e.unit = 1'b0; e.ack = ea; e.err = ee; e.tag = tag;
    sb.push_back(e);
  endtask

  // Unit-spacer word: bits outside mask at spacer (11), bad bits at 00.
  task automatic apply_u(input logic [UW-1:0] w, input logic [UW-1:0] m,
                         input logic [UW-1:0] bad, input logic down,
                         input bit ea, input bit ee, input string tag);
    exp_t e;
    @(negedge clk);
    ut    = ((w & m) | ~m) & ~bad;
    uf    = ((~w & m) | ~m) & ~bad;
    udown = down;
    repeat (3) @(posedge clk);
    #1;
    e.unit = 1'b1; e.ack = ea; e.err = ee; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pops expectations and compares against the matching instance.
  initial begin
    forever begin
      exp_t e;
      wait (sb.size() > 0);
      e = sb.pop_front();
      if (e.unit) chk(e.tag, {u_ack, u_err}, {e.ack, e.err});
      else        chk(e.tag, {z_ack, z_err}, {e.ack, e.err});
    end
  end

  initial begin
    #(20 * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  localparam logic [ZW-1:0] ALL  = '1;
  localparam logic [ZW-1:0] NONE = '0;
  localparam logic [UW-1:0] UALL = '1;
  localparam logic [UW-1:0] UNONE = '0;

  initial begin
    // R1: outputs low during reset even with full work words presented
    @(negedge clk);
    zt = 64'hA5A5_A5A5_A5A5_A5A5; zf = ~zt; zdown = 1'b1;
    ut = 16'h00FF; uf = 16'hFF00; udown = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 zero reset", {z_ack, z_err}, 2'b00);
    chk("R1 unit reset", {u_ack, u_err}, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 zero first cycle after reset", {z_ack, z_err}, 2'b00);
    chk("R1 unit first cycle after reset", {u_ack, u_err}, 2'b00);

    apply_z(NONE, NONE, NONE, 1'b0, 1'b0, 1'b0, "R4 zero start at spacer");
    apply_u(UNONE, UNONE, UNONE, 1'b0, 1'b0, 1'b0, "R8 unit start at spacer");

    // R2: exact latency of three edges
    @(negedge clk);
    zt = 64'h0123_4567_89AB_CDEF; zf = ~zt; zdown = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R2 ack not yet after two edges", {z_ack, z_err}, 2'b00);
    @(posedge clk); #1;
    chk("R2 ack after third edge", {z_ack, z_err}, 2'b10);

    // R4: partial spacer keeps ack, down_ind high keeps ack
    apply_z(64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0000, NONE, 1'b0,
            1'b1, 1'b0, "R4 half back at spacer holds ack");
    apply_z(NONE, NONE, NONE, 1'b1, 1'b1, 1'b0, "R4 down_ind high holds ack");
    apply_z(NONE, NONE, NONE, 1'b0, 1'b0, 1'b0, "R4 all spacer and down low drops ack");

    // R3: one bit still at spacer blocks ack
    apply_z(ALL, {1'b0, {(ZW-1){1'b1}}}, NONE, 1'b1, 1'b0, 1'b0, "R3 bit 63 at spacer");
    apply_z(ALL, ALL, NONE, 1'b1, 1'b1, 1'b0, "R3 last bit arrives");
    apply_z(NONE, {(ZW-1){1'b0}} | 64'h1, NONE, 1'b0, 1'b1, 1'b0, "R4 bit 0 still work");
    apply_z(NONE, NONE, NONE, 1'b0, 1'b0, 1'b0, "R4 back to spacer");

    // R5: down_ind gates the rise
    apply_z(64'hFFFF_0000_FFFF_0000, ALL, NONE, 1'b0, 1'b0, 1'b0, "R5 work but down_ind low");
    apply_z(64'hFFFF_0000_FFFF_0000, ALL, NONE, 1'b1, 1'b1, 1'b0, "R5 down_ind rises");

    // R6 + R7: illegal bit 5 while the word returns to spacer
    apply_z(NONE, NONE, 64'h20, 1'b0, 1'b1, 1'b1, "R6 set bit held through illegal, R7 err");
    apply_z(NONE, NONE, NONE, 1'b0, 1'b0, 1'b0, "R6 bit 5 to spacer drops ack, R7 err clears");

    // R6 + R7: illegal bit 0 from spacer keeps its indicator clear
    apply_z(NONE, NONE, 64'h1, 1'b0, 1'b0, 1'b1, "R7 illegal on spacer word");
    apply_z(64'h5555_5555_5555_5555, ~64'h1, 64'h1, 1'b1, 1'b0, 1'b1,
            "R6 clear bit held through illegal");
    apply_z(64'h5555_5555_5555_5555, ALL, NONE, 1'b1, 1'b1, 1'b0, "R6 bit 0 legal work");
    apply_z(NONE, NONE, NONE, 1'b0, 1'b0, 1'b0, "R4 zero final spacer");

    // R8: unit-spacer encoding
    apply_u(16'h3C5A, UALL, UNONE, 1'b1, 1'b1, 1'b0, "R8 unit work word");
    apply_u(16'h3C5A, 16'h00F0, UNONE, 1'b0, 1'b1, 1'b0, "R8 unit partial spacer holds");
    apply_u(UNONE, UNONE, UNONE, 1'b0, 1'b0, 1'b0, "R8 unit all spacer drops");
    apply_u(UNONE, UNONE, 16'h0008, 1'b0, 1'b0, 1'b1, "R8 unit both rails low illegal");
    apply_u(16'hFFFF, ~16'h0008, 16'h0008, 1'b1, 1'b0, 1'b1, "R8 unit illegal bit blocks ack");
    apply_u(16'hFFFF, UALL, UNONE, 1'b1, 1'b1, 1'b0, "R8 unit recovers");
    apply_u(16'h8001, {1'b0, {(UW-1){1'b1}}}, UNONE, 1'b0, 1'b1, 1'b0,
            "R8 unit one bit spacer holds");

    wait (sb.size() == 0);
    #2;
    report();
  end

endmodule